// File: doc/BRIEF.md
# Request Reassembly Splitter

This block sits on the receive side between a TCP byte stream and a key-value engine. Input arrives as 64-bit beats in connection order. Network packets may end mid-beat, so a beat may carry fewer than eight bytes. A single packet may hold many requests, up to sixteen in the intended workload, and a request may begin in one packet and end in a later one. The input beat boundaries therefore say nothing about where requests begin or end.

Each request starts with a 24-byte binary header. The body length in that header tells the block how many bytes belong to the request. Incoming bytes go into a circular byte buffer. Once the header of the oldest request is held, the block waits until every byte of that request is present. It then sends the request out on a streaming interface. The first byte of the request sits in lane 0 of the first beat, and the end of the request is marked on its final beat. A request too large for the buffer is discarded as its bytes arrive, and an error counter records it.

Top module: `req_splitter`

## Requirements
- R1: While reset is asserted, m_tvalid is 0 and err_cnt is 0; after reset, with an empty buffer, s_tready is 1.
- R2: Output bytes of each forwarded request equal the input stream bytes of that request in order, and the request's first byte lies in lane 0 (bits 7:0) of its first output beat. Input byte lane k is s_tdata[8k+7:8k], with lane 0 first in stream order.
- R3: No beat of a request is presented before all of its bytes have been accepted at the input. A partially received request leaves m_tvalid at 0 and stays buffered until the rest arrives.
- R4: A request of L bytes leaves in ceil(L/8) beats. Every beat but the last has m_tkeep = 8'hFF and m_tlast = 0. The last beat has m_tlast = 1 and keeps the low ((L-1) mod 8)+1 lanes.
- R5: While m_tvalid is 1 and m_tready is 0, m_tdata, m_tkeep and m_tlast hold their values.
- R6: The buffer never holds more than its capacity. s_tready falls to 0 once fewer than eight free byte slots remain, so a stalled output eventually halts the input, and no byte is lost.
- R7: The header body length is the big-endian 32-bit value at header bytes 8..11, and the request length is 24 plus that value. A request longer than MAX_REQ bytes produces no output beat, its bytes are discarded, and err_cnt rises by exactly one. The request that follows it is forwarded intact. A request of exactly MAX_REQ bytes is forwarded.
- R8: Input s_tkeep is a contiguous mask from lane 0, and it may take any byte count from 0 to 8 on any beat. A beat with s_tkeep = 0 adds nothing to the stream. Requests packed back to back and requests split across beats at any offset are all forwarded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | 64 | Input stream bytes, lane 0 first |
| s_tkeep | input | 8 | Contiguous valid-byte mask from lane 0 |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with s_tvalid |
| m_tdata | output | 64 | Request bytes, realigned to lane 0 |
| m_tkeep | output | 8 | Valid lanes of the output beat |
| m_tlast | output | 1 | Final beat of a request |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| err_cnt | output | 16 | Count of oversized requests dropped |

## Verification
The hardest condition to reach from the ports combines several events: an oversized request whose bytes arrive while the buffer is nearly full, and whose trailing bytes straddle irregular beat sizes just before a valid request. The stimulus builds a byte stream that mixes directed lengths (0, 1 and 7 body bytes, exactly MAX_REQ, MAX_REQ plus one) with random ones. It chops that stream into beats of random size from 0 to 8 bytes, and throttles the output with long stretches of zero ready. The discard therefore overlaps a full buffer and arbitrary lane offsets. A separate phase feeds only part of a request and holds the input back, to show that nothing leaves early.

// File: rtl/req_splitter.sv
module req_splitter #(
  parameter int NB      = 8,
  parameter int MAX_REQ = 256,
  parameter int HDR     = 24,
  parameter int ERR_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB*8-1:0]  s_tdata,
  input  logic [NB-1:0]    s_tkeep,
  input  logic             s_tvalid,
  output logic             s_tready,
  output logic [NB*8-1:0]  m_tdata,
  output logic [NB-1:0]    m_tkeep,
  output logic             m_tlast,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [ERR_W-1:0] err_cnt
);
  localparam int DEPTH = 2 ** $clog2(2 * MAX_REQ);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(NB + 1);
  localparam logic [AW:0] ROOM_LIM = (AW+1)'(DEPTH - NB);
  localparam logic [31:0] MAX_BODY = 32'(MAX_REQ - HDR);

  typedef enum logic [1:0] {S_HUNT, S_SEND, S_DROP} st_t;

  logic [7:0]    mem [DEPTH];
  logic [AW:0]   wp, rp, fill;
  logic [CW-1:0] in_n, out_n, drop_n;
  logic [32:0]   left, need, room_lim;
  logic [31:0]   body;
  st_t           st;
  logic          s_fire, take;

  assign fill     = wp - rp;
  assign s_tready = (fill <= ROOM_LIM);
  assign s_fire   = s_tvalid && s_tready;
  assign m_tvalid = (st == S_SEND);
  assign take     = m_tvalid && m_tready;
  assign m_tlast  = (left <= 33'(NB));

  assign body = {mem[rp[AW-1:0] + AW'(8)],  mem[rp[AW-1:0] + AW'(9)],
                 mem[rp[AW-1:0] + AW'(10)], mem[rp[AW-1:0] + AW'(11)]};
  assign need = {1'b0, body} + 33'(HDR);

  always_comb begin
    in_n = '0;
    for (int i = 0; i < NB; i++)
      if (s_tkeep[i]) in_n = in_n + CW'(1);
  end

  assign out_n    = (left < 33'(NB)) ? CW'(left) : CW'(NB);
  assign room_lim = (fill < (AW+1)'(NB)) ? 33'(fill) : 33'(NB);
  assign drop_n   = (left < room_lim) ? CW'(left) : CW'(room_lim);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      m_tkeep[i]       = (CW'(i) < out_n);
      m_tdata[i*8 +: 8] = m_tkeep[i] ? mem[rp[AW-1:0] + AW'(i)] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (s_fire)
      for (int i = 0; i < NB; i++)
        if (CW'(i) < in_n) mem[wp[AW-1:0] + AW'(i)] <= s_tdata[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      st      <= S_HUNT;
      left    <= '0;
      err_cnt <= '0;
    end else begin
      if (s_fire) wp <= wp + (AW+1)'(in_n);
      case (st)
        S_HUNT:
          if (fill >= (AW+1)'(HDR)) begin
            if (body > MAX_BODY) begin
              st      <= S_DROP;
              left    <= need;
              err_cnt <= err_cnt + ERR_W'(1);
            end else if (33'(fill) >= need) begin
              st   <= S_SEND;
              left <= need;
            end
          end
        S_SEND:
          if (take) begin
            rp   <= rp + (AW+1)'(out_n);
            left <= left - 33'(out_n);
            if (m_tlast) st <= S_HUNT;
          end
        S_DROP: begin
          rp   <= rp + (AW+1)'(drop_n);
          left <= left - 33'(drop_n);
          if (left == 33'(drop_n)) st <= S_HUNT;
        end
        default: st <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/req_splitter_chk.sv
module req_splitter_chk #(
  parameter int NB    = 8,
  parameter int AW    = 9,
  parameter int ERR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NB*8-1:0]  m_tdata,
  input logic [NB-1:0]    m_tkeep,
  input logic             m_tlast,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic [ERR_W-1:0] err_cnt,
  input logic [AW:0]      fill
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (!m_tvalid && err_cnt == '0));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)));

  p_full_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tlast) |-> (m_tkeep == {NB{1'b1}}));

  p_keep_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tkeep[0] && ((m_tkeep & NB'(m_tkeep + NB'(1))) == '0)));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(2 ** AW));

  p_err_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_cnt == $past(err_cnt) || err_cnt == ERR_W'($past(err_cnt) + ERR_W'(1))));
endmodule

bind req_splitter req_splitter_chk #(.NB(NB), .AW(AW), .ERR_W(ERR_W)) u_chk (.*);

// File: tb/sim_req_splitter.sv
module sim_req_splitter;
  localparam int NB = 8, MAX_REQ = 256, HDR = 24, LIMIT = 150000;

  logic clk = 0, rst_n = 0;
  logic [NB*8-1:0] s_tdata = '0, m_tdata;
  logic [NB-1:0]   s_tkeep = '0, m_tkeep;
  logic s_tvalid = 0, s_tready, m_tlast, m_tvalid, m_tready = 0;
  logic [15:0] err_cnt;

  always #2 clk = ~clk;

  req_splitter #(.NB(NB), .MAX_REQ(MAX_REQ), .HDR(HDR), .ERR_W(16)) u0 (.*);

  logic [7:0] sbuf[$];
  int exp_start[$], exp_len[$];
  int n_checks = 0, n_err = 0, n_drop_exp = 0;
  int sp = 0, feed_lim = 0, rq = 0, off = 0, cyc = 0, cur_n = 0;
  bit pend = 0, saw_full = 0, timed_out = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic add_req(int bodylen);
    int len = HDR + bodylen;
    int st = sbuf.size();
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      if (i == 0) b = 8'h80;
      else if (i == 8)  b = 8'(bodylen >> 24);
      else if (i == 9)  b = 8'(bodylen >> 16);
      else if (i == 10) b = 8'(bodylen >> 8);
      else if (i == 11) b = 8'(bodylen);
      sbuf.push_back(b);
    end
    if (len <= MAX_REQ) begin
      exp_start.push_back(st);
      exp_len.push_back(len);
    end else n_drop_exp++;
  endtask

  task automatic check_beat();
    logic [63:0] ed = '0, ad;
    logic [7:0] ek = '0;
    int rem, en;
    if (rq >= exp_len.size()) begin
      check(0, "R3 unexpected beat", m_tdata, 0);
      return;
    end
    rem = exp_len[rq] - off;
    en = rem < NB ? rem : NB;
    for (int i = 0; i < en; i++) begin
      ed[i*8 +: 8] = sbuf[exp_start[rq] + off + i];
      ek[i] = 1'b1;
    end
    ad = m_tdata & {{8{ek[7]}},{8{ek[6]}},{8{ek[5]}},{8{ek[4]}},
                    {8{ek[3]}},{8{ek[2]}},{8{ek[1]}},{8{ek[0]}}};
    check(ad == ed, "R2 data", ad, ed);
    check(m_tkeep == ek && m_tlast == (rem <= NB), "R4 keep/last",
          {55'd0, m_tlast, m_tkeep}, {55'd0, rem <= NB, ek});
    off += en;
    if (off >= exp_len[rq]) begin rq++; off = 0; end
  endtask

  task automatic step(int rdy_pct);
    @(negedge clk);
    if (!pend) begin
      int avail = feed_lim - sp;
      int n = $urandom_range(0, NB);
      if (n > avail) n = avail;
      cur_n = n;
      s_tdata = 64'($urandom) << 32 | 64'($urandom);
      for (int i = 0; i < n; i++) s_tdata[i*8 +: 8] = sbuf[sp + i];
      s_tkeep = 8'((9'd1 << n) - 9'd1);
      s_tvalid = (n > 0) || ($urandom_range(0, 7) == 0);
      pend = s_tvalid;
    end
    m_tready = ($urandom_range(0, 99) < rdy_pct);
    #1;
    if (s_tvalid && s_tready) begin sp += cur_n; pend = 0; end
    if (m_tvalid && m_tready) check_beat();
    if (!s_tready) saw_full = 1;
    cyc++;
    if (cyc > LIMIT) timed_out = 1;
  endtask

  task automatic drain(int rdy_pct);
    feed_lim = sbuf.size();
    while (!timed_out && !(sp == sbuf.size() && rq == exp_len.size() && !pend)) step(rdy_pct);
    for (int i = 0; i < 30; i++) step(rdy_pct);
  endtask

  initial begin
    logic [63:0] hd;
    logic [7:0] hk;
    repeat (4) @(negedge clk);
    check(!m_tvalid && err_cnt == 0, "R1 reset outputs", {m_tvalid, 16'(err_cnt)}, 0);
    rst_n = 1;
    @(negedge clk);
    check(s_tready == 1, "R1 ready after reset", s_tready, 1);

    add_req(40);
    feed_lim = 50;
    for (int i = 0; i < 40; i++) step(100);
    check(!m_tvalid && rq == 0 && sp == 50, "R3 partial held", {m_tvalid, 32'(rq)}, 0);
    drain(100);

    add_req(0); add_req(1); add_req(MAX_REQ - HDR);
    add_req(MAX_REQ - HDR + 1); add_req(7); add_req(0);
    add_req(MAX_REQ); add_req(3);
    drain(70);
    check(err_cnt == 16'(n_drop_exp), "R7 err after directed", err_cnt, n_drop_exp);

    for (int i = 0; i < 20; i++) add_req($urandom_range(0, 60));
    feed_lim = sbuf.size();
    for (int i = 0; i < 200; i++) step(0);
    check(saw_full, "R6 input halted when full", saw_full, 1);
    check(m_tvalid, "R6 request pending", m_tvalid, 1);
    hd = m_tdata; hk = m_tkeep;
    for (int i = 0; i < 3; i++) step(0);
    check(m_tdata == hd && m_tkeep == hk, "R5 stable under stall", m_tdata, hd);
    drain(50);

    for (int i = 0; i < 80; i++)
      if ($urandom_range(0, 9) == 0) add_req($urandom_range(MAX_REQ - HDR + 1, 2 * MAX_REQ));
      else add_req($urandom_range(0, MAX_REQ - HDR));
    drain(60);

    check(!timed_out, "R8 watchdog", cyc, LIMIT);
    check(rq == exp_len.size(), "R8 all requests forwarded", rq, exp_len.size());
    check(err_cnt == 16'(n_drop_exp), "R7 drop count", err_cnt, n_drop_exp);
    check(!m_tvalid, "R3 no spurious output", m_tvalid, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule